// File: doc/BRIEF.md
# Bus-Master Disk DMA Register File

This block holds the software-visible control state of a bus-master disk DMA engine. A host reaches it over a simple register bus with byte enables. Through that bus it sets up three registers:

- a command byte that starts and stops a transfer and sets its direction;
- a status byte that mixes engine events with software-owned flags;
- a 32-bit pointer to the descriptor table in memory.

The start, direction and pointer values go straight out to the transfer engine. The engine reports back through a level that says a transfer is running and through one-cycle pulses for error and interrupt events.

Two verdicts are derived combinationally from the stored status byte. The completion verdict tells a driver whether a finished transfer ended cleanly. The timeout verdict tells a watchdog handler whether to keep waiting, fail the request, or reset the bus.

Reads have no strobe: `reg_rdata` always shows the register selected by `reg_addr`. A write takes effect at the clock edge where `reg_wr` is high. All control and status pins are plain levels or pulses, and the block has no valid/ready handshake because nothing streams through it.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, every register reads 0 and `dma_start`, `dma_to_mem`, `irq`, `done_ok` and `table_ptr` are 0.
- R2: The command register sits at offset 0. Bit 0 is start and drives `dma_start`; bit 3 is direction and drives `dma_to_mem` (1 means drive-to-memory). All other command bits read 0. A write updates the register one clock after it is presented, and only when `reg_be[0]` is high.
- R3: The table pointer sits at offset 4. It is written per byte lane under `reg_be[3:0]` and drives `table_ptr`; its bits 1:0 always read 0.
- R4: Status bits 3, 4, 5 and 6 are plain read/write flags. Bit 5 marks drive unit 0 as DMA-capable and bit 6 marks unit 1. Each holds the last value written at offset 2.
- R5: Status bit 1 (error) and bit 2 (interrupt) are set by one-cycle `eng_err` and `eng_intr` pulses. Writing 1 to such a bit clears it and writing 0 leaves it unchanged. If an event arrives in the same cycle as a clear, the event wins.
- R6: Status bit 0 (active) follows `eng_active` one cycle later. Writes to it are ignored.
- R7: Status bit 7 always reads 0, and reads at any offset other than 0, 2 or 4 return 0.
- R8: `irq` equals status bit 2.
- R9: `done_ok` is 1 only when, among status bits 2:0, the interrupt bit alone is set. `done_code` is 0 when `done_ok` is 1 and otherwise equals the status byte with bit 4 forced to 1.
- R10: `tmo_verdict` (0 = keep waiting, 1 = fail, 2 = reset bus) is decided in this order. Status bits 3 and 4 both set gives 0. Otherwise error set gives 1. Otherwise active or interrupt set gives 0. Otherwise the verdict is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Byte offset of the register |
| reg_be | input | 4 | Byte-lane enables, relative to the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| eng_active | input | 1 | Engine is transferring |
| eng_err | input | 1 | One-cycle error event |
| eng_intr | input | 1 | One-cycle interrupt event |
| dma_start | output | 1 | Start/run request to the engine |
| dma_to_mem | output | 1 | Direction: 1 means drive to memory |
| table_ptr | output | 32 | Descriptor table address |
| irq | output | 1 | Interrupt request |
| done_ok | output | 1 | Completion verdict is good |
| done_code | output | 8 | Error code for a bad completion, else 0 |
| tmo_verdict | output | 2 | Timeout verdict |

## Verification
The verdict logic is driven through status patterns that the bench builds with real engine events and bus writes.

- Interrupt alone separates a good completion from every other pattern.
- Interrupt with the free bits 3 and 4 set shows that those bits lie outside the completion mask.
- Error together with both bits 3 and 4 shows that the keep-waiting rule outranks fail.
- Bit 3 or bit 4 on its own shows that both must be set for that rule to apply.

Directed cases cover a clear in the same cycle as an event, writes to the read-only bits, partial byte-lane writes to the pointer, and read-modify-write of the command byte.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam logic [2:0] CMD_OFS  = 3'd0;
  localparam logic [2:0] STAT_OFS = 3'd2;
  localparam logic [2:0] PTR_OFS  = 3'd4;

  // command bit positions
  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 3;

  // status bit positions
  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_INT  = 2;
  localparam int unsigned ST_AUXA = 3;
  localparam int unsigned ST_AUXB = 4;
  localparam int unsigned ST_CAP0 = 5;
  localparam int unsigned ST_CAP1 = 6;

  localparam logic [7:0] BAD_FLAG = 8'h10;

  typedef enum logic [1:0] {
    TMO_WAIT  = 2'd0,
    TMO_FAIL  = 2'd1,
    TMO_RESET = 2'd2
  } tmo_e;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       run_in,
  input  logic       dir_in,
  output logic       run,
  output logic       to_mem,
  output logic [7:0] cmd_byte
);
  logic run_q, dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (we) begin
      run_q <= run_in;
      dir_q <= dir_in;
    end
  end

  always_comb begin
    cmd_byte          = 8'h00;
    cmd_byte[CMD_RUN] = run_q;
    cmd_byte[CMD_DIR] = dir_q;
  end

  assign run    = run_q;
  assign to_mem = dir_q;
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [6:1] wr_bits,
  input  logic       act_lvl,
  input  logic       err_evt,
  input  logic       int_evt,
  output logic [7:0] stat
);
  logic act_q, err_q, int_q;
  logic [3:0] flag_q;   // bits 6:3, plain read/write

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      int_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      act_q <= act_lvl;
      // an event in the same cycle as a clear wins
      err_q <= (err_q & ~(we & wr_bits[ST_ERR])) | err_evt;
      int_q <= (int_q & ~(we & wr_bits[ST_INT])) | int_evt;
      if (we) flag_q <= wr_bits[ST_CAP1:ST_AUXA];
    end
  end

  assign stat = {1'b0, flag_q, int_q, err_q, act_q};
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [PTR_W/8-1:0]          be,
  input  logic [PTR_W-1:ALIGN_BITS]   hi_wdata,
  output logic [PTR_W-1:0]            ptr
);
  logic [PTR_W-1:ALIGN_BITS] q;

  for (genvar b = 0; b < PTR_W; b++) begin : g_bit
    if (b < ALIGN_BITS) begin : g_zero
      assign ptr[b] = 1'b0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) q[b] <= 1'b0;
        else if (we && be[b/8]) q[b] <= hi_wdata[b];
      end
      assign ptr[b] = q[b];
    end
  end
endmodule

// File: rtl/bmdma_verdict.sv
module bmdma_verdict
  import bmdma_pkg::*;
(
  input  logic [7:0] stat,
  output logic       ok,
  output logic [7:0] code,
  output logic [1:0] tmo
);
  tmo_e v;

  always_comb begin
    ok   = ({stat[ST_INT], stat[ST_ERR], stat[ST_ACT]} == 3'b100);
    code = ok ? 8'h00 : (stat | BAD_FLAG);

    if (stat[ST_AUXA] && stat[ST_AUXB])       v = TMO_WAIT;
    else if (stat[ST_ERR])                    v = TMO_FAIL;
    else if (stat[ST_ACT] || stat[ST_INT])    v = TMO_WAIT;
    else                                      v = TMO_RESET;

    tmo = v;
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned PTR_W      = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [PTR_W/8-1:0] reg_be,
  input  logic [PTR_W-1:0]   reg_wdata,
  output logic [PTR_W-1:0]   reg_rdata,
  input  logic               eng_active,
  input  logic               eng_err,
  input  logic               eng_intr,
  output logic               dma_start,
  output logic               dma_to_mem,
  output logic [PTR_W-1:0]   table_ptr,
  output logic               irq,
  output logic               done_ok,
  output logic [7:0]         done_code,
  output logic [1:0]         tmo_verdict
);
  localparam int unsigned PAD_W = PTR_W - 8;

  logic       cmd_we, stat_we, ptr_we;
  logic [7:0] cmd_byte, stat_q;

  assign cmd_we  = reg_wr && (reg_addr == CMD_OFS)  && reg_be[0];
  assign stat_we = reg_wr && (reg_addr == STAT_OFS) && reg_be[0];
  assign ptr_we  = reg_wr && (reg_addr == PTR_OFS);

  bmdma_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cmd_we),
    .run_in   (reg_wdata[CMD_RUN]),
    .dir_in   (reg_wdata[CMD_DIR]),
    .run      (dma_start),
    .to_mem   (dma_to_mem),
    .cmd_byte (cmd_byte)
  );

  bmdma_stat_reg u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (stat_we),
    .wr_bits (reg_wdata[6:1]),
    .act_lvl (eng_active),
    .err_evt (eng_err),
    .int_evt (eng_intr),
    .stat    (stat_q)
  );

  bmdma_ptr_reg #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ptr_we),
    .be       (reg_be),
    .hi_wdata (reg_wdata[PTR_W-1:ALIGN_BITS]),
    .ptr      (table_ptr)
  );

  bmdma_verdict u_verdict (
    .stat (stat_q),
    .ok   (done_ok),
    .code (done_code),
    .tmo  (tmo_verdict)
  );

  assign irq = stat_q[ST_INT];

  always_comb begin
    unique case (reg_addr)
      CMD_OFS:  reg_rdata = {{PAD_W{1'b0}}, cmd_byte};
      STAT_OFS: reg_rdata = {{PAD_W{1'b0}}, stat_q};
      PTR_OFS:  reg_rdata = table_ptr;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk
  import bmdma_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [2:0]            reg_addr,
  input logic                  be0,
  input logic                  clr_int_bit,
  input logic                  eng_active,
  input logic                  eng_err,
  input logic                  eng_intr,
  input logic                  dma_start,
  input logic                  irq,
  input logic                  done_ok,
  input logic [1:0]            tmo_verdict,
  input logic [ALIGN_BITS-1:0] ptr_lo,
  input logic [7:0]            stat
);
  // R2
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == CMD_OFS && be0) |=> $stable(dma_start));

  // R3
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_lo == '0);

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> stat[ST_ERR]);

  // R5
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STAT_OFS && be0 && clr_int_bit && !eng_intr) |=> !irq);

  // R6
  act_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |=> stat[ST_ACT]);

  // R8
  irq_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_intr |=> irq);

  // R9
  done_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (irq && !stat[ST_ERR] && !stat[ST_ACT]));

  // R10
  tmo_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[ST_AUXA] && stat[ST_AUXB]) |-> (tmo_verdict == TMO_WAIT));
endmodule

bind bmdma_regs bmdma_regs_chk #(.ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .be0         (reg_be[0]),
  .clr_int_bit (reg_wdata[2]),
  .eng_active  (eng_active),
  .eng_err     (eng_err),
  .eng_intr    (eng_intr),
  .dma_start   (dma_start),
  .irq         (irq),
  .done_ok     (done_ok),
  .tmo_verdict (tmo_verdict),
  .ptr_lo      (table_ptr[ALIGN_BITS-1:0]),
  .stat        (stat_q)
);

// File: tb/bmdma_regs_tb.sv
`timescale 1ns/1ps
module bmdma_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_active = 1'b0, eng_err = 1'b0, eng_intr = 1'b0;
  logic        dma_start, dma_to_mem, irq, done_ok;
  logic [31:0] table_ptr;
  logic [7:0]  done_code;
  logic [1:0]  tmo_verdict;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bmdma_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_active(eng_active), .eng_err(eng_err), .eng_intr(eng_intr),
    .dma_start(dma_start), .dma_to_mem(dma_to_mem), .table_ptr(table_ptr),
    .irq(irq), .done_ok(done_ok), .done_code(done_code),
    .tmo_verdict(tmo_verdict)
  );

  // {act, err, int, aux3, aux4, exp_ok, exp_tmo[1:0]}
  localparam int NV = 11;
  localparam logic [7:0] VEC [NV] = '{
    8'b00000_0_10, 8'b00100_1_00, 8'b01000_0_01, 8'b10000_0_00,
    8'b10100_0_00, 8'b01100_0_01, 8'b00111_1_00, 8'b01011_0_00,
    8'b00010_0_10, 8'b01001_0_01, 8'b11100_0_01
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); chk("R1 cmd", r, 0);
    rd(3'd2, r); chk("R1 stat", r, 0);
    rd(3'd4, r); chk("R1 ptr", r, 0);
    chk("R1 outs", {dma_start, dma_to_mem, irq, done_ok}, 0);

    // R9 R10 verdict vectors
    for (int i = 0; i < NV; i++) begin
      logic [7:0] v, st, expc;
      v = VEC[i];
      wr(3'd2, {27'd0, v[3], v[4], 2'b11, 1'b0}, 4'h1);
      eng_active = v[7]; eng_err = v[6]; eng_intr = v[5];
      @(negedge clk);
      eng_err = 1'b0; eng_intr = 1'b0;
      st   = {3'b000, v[3], v[4], v[5], v[6], v[7]};
      expc = v[2] ? 8'h00 : (st | 8'h10);
      rd(3'd2, r);
      chk("R4 R5 R6 vec status", r, {24'd0, st});
      chk("R9 vec done_ok", {31'd0, done_ok}, {31'd0, v[2]});
      chk("R9 vec done_code", {24'd0, done_code}, {24'd0, expc});
      chk("R10 vec tmo", {30'd0, tmo_verdict}, {30'd0, v[1:0]});
      chk("R8 vec irq", {31'd0, irq}, {31'd0, v[5]});
      eng_active = 1'b0;
    end
    wr(3'd2, 32'h06, 4'h1);

    // R2 command register
    wr(3'd0, 32'hFF, 4'h1);
    rd(3'd0, r); chk("R2 cmd other bits zero", r, 32'h09);
    chk("R2 start/dir", {dma_start, dma_to_mem}, 2'b11);
    wr(3'd0, 32'h08, 4'h1);
    chk("R2 stop keeps dir", {dma_start, dma_to_mem}, 2'b01);
    wr(3'd0, 32'h01, 4'h0);
    rd(3'd0, r); chk("R2 be0 low ignored", r, 32'h08);

    // R3 pointer
    wr(3'd4, 32'hDEADBEEF, 4'hF);
    rd(3'd4, r); chk("R3 ptr align", r, 32'hDEADBEEC);
    wr(3'd4, 32'h11223344, 4'h2);
    chk("R3 ptr lane", table_ptr, 32'hDEAD33EC);

    // R4 capability bits, R7 bit 7 reads zero
    wr(3'd2, 32'hE0, 4'h1);
    rd(3'd2, r); chk("R4 R7 caps", r, 32'h60);
    wr(3'd2, 32'h20, 4'h1);
    rd(3'd2, r); chk("R4 unit0 only", r, 32'h20);

    // R6 active write ignored
    wr(3'd2, 32'h01, 4'h1);
    rd(3'd2, r); chk("R6 act write ignored", r, 32'h00);

    // R5 write 0 keeps, write 1 clears, event beats clear
    @(negedge clk); eng_intr = 1'b1; eng_err = 1'b1;
    @(negedge clk); eng_intr = 1'b0; eng_err = 1'b0;
    wr(3'd2, 32'h00, 4'h1);
    rd(3'd2, r); chk("R5 write0 keeps", r, 32'h06);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h04; reg_be = 4'h1; eng_intr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0; eng_intr = 1'b0;
    chk("R5 event wins", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h04, 4'h1);
    rd(3'd2, r); chk("R5 clear int only", r, 32'h02);
    chk("R8 irq low", {31'd0, irq}, 32'd0);

    // R7 unused offset
    rd(3'd6, r); chk("R7 unused offset", r, 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule